// File: doc/BRIEF.md
# Early Branch Resolution Unit

This block sits at the front of a five-stage, 32-bit RISC pipeline. It owns the fetch program counter and the register between fetch and decode. It also settles conditional branches while the branch is still in decode. The instruction in decode names one source register, and the register file returns that register's value. The block tests the value against zero and adds the sign-extended 16-bit displacement to the branch's incremented PC on an adder of its own. It then chooses the next fetch address in the same cycle. A taken branch therefore squashes only the one instruction fetched behind it, which costs a single bubble. Resolving the branch in the memory stage would cost three.

The pipeline's stall input is the only back-pressure. While it is high, the fetch counter and the fetch/decode register keep their values. The branch decision stays on the outputs unchanged. Instruction fetch is combinational from the fetch address, so the block has no valid/ready handshake: each unstalled clock edge takes in exactly one instruction word.

Bits of an instruction are numbered from 0 at the most significant end. Bits 0..5 hold the opcode, which is [31:26] in little-endian terms. Bits 6..10 hold the source register, [25:21]. Bits 11..15 hold a second register field, [20:16], which this block ignores. Bits 16..31 hold the immediate, [15:0].

Top module: `early_branch_unit`

## Requirements
- R1: A synchronous active-high reset sets the fetch address to 0 and loads the fetch/decode register with the all-zero no-op word, which also clears its stored incremented PC.
- R2: When no branch is taken and stall is low, each clock edge advances the fetch address by 4. The same edge loads the fetch/decode register with the fetched word and with the old fetch address plus 4.
- R3: The source-register index sent to the register file is instruction bits [25:21]. The opcode is bits [31:26]. The immediate is bits [15:0]. The second register field [20:16] has no effect on the outcome.
- R4: Opcode 0x04 is branch-if-zero. It is taken exactly when the source register value is zero.
- R5: Opcode 0x05 is branch-if-not-zero. It is taken exactly when the source register value is non-zero.
- R6: Every other opcode, including 0x00, never asserts redirect or flush, whatever the register value.
- R7: The branch target is the decoded instruction's incremented PC plus the immediate, sign-extended to 32 bits. This works for both forward and backward displacements.
- R8: In the cycle a taken branch sits in decode, redirect is high and next_pc equals the target. At the next unstalled edge the fetch address becomes the target and the fetch/decode register becomes the all-zero no-op, which is exactly one squashed slot.
- R9: While stall is high, the fetch address and the fetch/decode register hold. Redirect and next_pc stay stable, and flush is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Pipeline hold; freezes fetch address and fetch/decode register |
| fetch_instr | input | 32 | Instruction word read at fetch_pc |
| fetch_pc | output | 32 | Current fetch address |
| rs_addr | output | 5 | Source-register index of the instruction in decode |
| rs_data | input | 32 | Register-file value for rs_addr |
| next_pc | output | 32 | Address fetch loads at the next unstalled edge |
| redirect | output | 1 | Instruction in decode is a taken branch |
| flush | output | 1 | Fetch/decode register is replaced by a no-op at this edge |
| id_instr | output | 32 | Instruction held in the fetch/decode register |
| id_npc | output | 32 | Incremented PC held with that instruction |

## Verification
A stream of non-branch words checks straight-line advance. One of these words has opcode 0x00 and one has source register zero, so a zero value alone cannot fire a redirect. Each branch opcode is then run with the register at zero and at non-zero, with forward and backward displacements. These runs separate the two polarities and show a sign-extension fault. Stall is held over a taken branch in decode to show that the squash waits for the first unstalled edge and never repeats. One word puts a non-zero register in the second register field, which shows that only bits [25:21] are read.

// File: rtl/ebr_pkg.sv
package ebr_pkg;

  localparam int unsigned OPC_W = 6;

  localparam logic [OPC_W-1:0] OPC_BR_EQZ = 6'h04;
  localparam logic [OPC_W-1:0] OPC_BR_NEZ = 6'h05;

  typedef enum logic [1:0] {
    BR_NONE = 2'd0,
    BR_EQZ  = 2'd1,
    BR_NEZ  = 2'd2
  } br_kind_e;

endpackage

// File: rtl/ebr_field_decode.sv
module ebr_field_decode
  import ebr_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned RA_W  = 5,
  parameter int unsigned IMM_W = 16
) (
  input  logic [XLEN-1:0]  instr,
  output br_kind_e         kind,
  output logic [RA_W-1:0]  rs_idx,
  output logic [IMM_W-1:0] imm
);

  // Fields counted from the most significant end: opcode, source, second reg.
  localparam int unsigned OPC_LO = XLEN - OPC_W;
  localparam int unsigned RS_LO  = OPC_LO - RA_W;

  logic [OPC_W-1:0] opcode;
  logic             unused_second_field;

  assign opcode = instr[XLEN-1 -: OPC_W];
  assign rs_idx = instr[OPC_LO-1 -: RA_W];
  assign imm    = instr[IMM_W-1:0];
  assign unused_second_field = ^instr[RS_LO-1:IMM_W];

  always_comb begin
    case (opcode)
      OPC_BR_EQZ: kind = BR_EQZ;
      OPC_BR_NEZ: kind = BR_NEZ;
      default:    kind = BR_NONE;
    endcase
  end

endmodule

// File: rtl/ebr_zero_test.sv
module ebr_zero_test
  import ebr_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  br_kind_e        kind,
  input  logic [XLEN-1:0] rs_val,
  output logic            taken
);

  logic is_zero;

  assign is_zero = ~|rs_val;

  always_comb begin
    case (kind)
      BR_EQZ:  taken = is_zero;
      BR_NEZ:  taken = ~is_zero;
      default: taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/ebr_target_adder.sv
module ebr_target_adder #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IMM_W = 16
) (
  input  logic [XLEN-1:0]  base,
  input  logic [IMM_W-1:0] disp,
  output logic [XLEN-1:0]  target
);

  localparam int unsigned EXT_W = XLEN - IMM_W;

  logic [XLEN-1:0] disp_ext;

  assign disp_ext = {{EXT_W{disp[IMM_W-1]}}, disp};
  assign target   = base + disp_ext;

endmodule

// File: rtl/early_branch_unit.sv
module early_branch_unit
  import ebr_pkg::*;
#(
  parameter int unsigned   XLEN        = 32,
  parameter int unsigned   RA_W        = 5,
  parameter int unsigned   IMM_W       = 16,
  parameter int unsigned   INSTR_BYTES = 4,
  parameter logic [31:0]   RESET_PC    = 32'h0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stall,
  input  logic [XLEN-1:0] fetch_instr,
  output logic [XLEN-1:0] fetch_pc,
  output logic [RA_W-1:0] rs_addr,
  input  logic [XLEN-1:0] rs_data,
  output logic [XLEN-1:0] next_pc,
  output logic            redirect,
  output logic            flush,
  output logic [XLEN-1:0] id_instr,
  output logic [XLEN-1:0] id_npc
);

  localparam logic [XLEN-1:0] STEP    = XLEN'(INSTR_BYTES);
  localparam logic [XLEN-1:0] PC_INIT = XLEN'(RESET_PC);

  logic [XLEN-1:0]  pc_q;
  logic [XLEN-1:0]  ir_q;
  logic [XLEN-1:0]  npc_q;
  logic [XLEN-1:0]  seq_pc;
  logic [XLEN-1:0]  br_target;
  logic [IMM_W-1:0] imm;
  br_kind_e         kind;
  logic             taken;

  ebr_field_decode #(.XLEN(XLEN), .RA_W(RA_W), .IMM_W(IMM_W)) u_dec (
    .instr  (ir_q),
    .kind   (kind),
    .rs_idx (rs_addr),
    .imm    (imm)
  );

  ebr_zero_test #(.XLEN(XLEN)) u_zt (
    .kind   (kind),
    .rs_val (rs_data),
    .taken  (taken)
  );

  ebr_target_adder #(.XLEN(XLEN), .IMM_W(IMM_W)) u_tgt (
    .base   (npc_q),
    .disp   (imm),
    .target (br_target)
  );

  assign seq_pc   = pc_q + STEP;
  assign next_pc  = taken ? br_target : seq_pc;
  assign redirect = taken;
  assign flush    = taken & ~stall;
  assign fetch_pc = pc_q;
  assign id_instr = ir_q;
  assign id_npc   = npc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= PC_INIT;
      ir_q  <= '0;
      npc_q <= '0;
    end else if (!stall) begin
      pc_q <= next_pc;
      if (taken) begin
        ir_q  <= '0;
        npc_q <= '0;
      end else begin
        ir_q  <= fetch_instr;
        npc_q <= seq_pc;
      end
    end
  end

  // R1: reset state
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (pc_q == PC_INIT && ir_q == '0 && npc_q == '0));

  // R2: straight-line advance
  a_r2_seq_advance: assert property (@(posedge clk) disable iff (rst)
    (!stall && !redirect) |=> (pc_q == $past(pc_q) + STEP));

  // R6: non-branch opcodes never redirect
  a_r6_no_branch_quiet: assert property (@(posedge clk) disable iff (rst)
    (kind == BR_NONE) |-> (!redirect && !flush));

  // R8: squash loads a no-op and the target
  a_r8_flush_bubble: assert property (@(posedge clk) disable iff (rst)
    flush |=> (ir_q == '0 && pc_q == $past(br_target)));

  // R9: stall freezes state
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (rst)
    stall |=> ($stable(pc_q) && $stable(ir_q) && $stable(npc_q)));

endmodule

// File: tb/tb_early_branch_unit.sv
module tb_early_branch_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stall = 1'b0;
  logic [31:0] fetch_instr, fetch_pc, rs_data, next_pc, id_instr, id_npc;
  logic [4:0]  rs_addr;
  logic        redirect, flush;

  logic [31:0] imem [64];
  logic [31:0] regs [32];

  int n_cmp = 0;
  int n_bad = 0;

  logic [31:0] m_pc, m_ir, m_npc;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign fetch_instr = imem[fetch_pc[7:2]];
  assign rs_data     = regs[rs_addr];

  early_branch_unit dut (
    .clk(clk), .rst(rst), .stall(stall), .fetch_instr(fetch_instr),
    .fetch_pc(fetch_pc), .rs_addr(rs_addr), .rs_data(rs_data),
    .next_pc(next_pc), .redirect(redirect), .flush(flush),
    .id_instr(id_instr), .id_npc(id_npc)
  );

  function automatic logic [31:0] enc(input logic [5:0] op, input logic [4:0] rs,
                                      input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 64; i++) imem[i] = 32'h0;
    for (int i = 0; i < 32; i++) regs[i] = (i == 0) ? 32'h0 : 32'h100 + i;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    stall = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 fetch_pc", fetch_pc, 32'h0);
    chk("R1 id_instr", id_instr, 32'h0);
    chk("R1 id_npc", id_npc, 32'h0);
    m_pc = 0; m_ir = 0; m_npc = 0;
  endtask

  // One cycle against the reference: check outputs, cross the edge, advance model.
  task automatic step(input logic st, input string tag);
    logic [5:0]  op;
    logic [31:0] v, tgt, nxt, cur;
    logic        tk;
    stall = st;
    #1;
    op  = m_ir[31:26];
    v   = regs[m_ir[25:21]];
    tk  = (op == 6'h04 && v == 0) || (op == 6'h05 && v != 0);
    tgt = m_npc + {{16{m_ir[15]}}, m_ir[15:0]};
    nxt = tk ? tgt : m_pc + 32'd4;
    cur = imem[m_pc[7:2]];
    chk({tag, " R2 fetch_pc"}, fetch_pc, m_pc);
    chk({tag, " R2 id_instr"}, id_instr, m_ir);
    chk({tag, " R3 rs_addr"}, {27'h0, rs_addr}, {27'h0, m_ir[25:21]});
    chk({tag, " R4 R5 redirect"}, {31'h0, redirect}, {31'h0, tk});
    chk({tag, " R7 next_pc"}, next_pc, nxt);
    chk({tag, " R9 flush"}, {31'h0, flush}, {31'h0, tk & ~st});
    @(posedge clk);
    if (!st) begin
      m_ir  = tk ? 32'h0 : cur;
      m_npc = tk ? 32'h0 : m_pc + 32'd4;
      m_pc  = nxt;
    end
    @(negedge clk);
  endtask

  task automatic t_sequential();
    clear_prog();
    for (int i = 0; i < 8; i++) imem[i] = enc(6'h08, 5'(i + 1), 5'(i + 2), 16'h0010);
    imem[2] = enc(6'h00, 5'd0, 5'd0, 16'hFFF0);   // R6: opcode 0, r0 is zero
    imem[4] = enc(6'h06, 5'd0, 5'd3, 16'h0004);   // R6: other opcode, zero source
    do_reset();
    for (int i = 0; i < 9; i++) step(1'b0, "seq");
    chk("R2 fetch_pc after 9", fetch_pc, 32'd36);
    chk("R2 id_npc", id_npc, 32'd36);
  endtask

  task automatic t_eqz_forward();
    clear_prog();
    regs[9] = 32'h0;
    imem[2] = enc(6'h04, 5'd9, 5'd7, 16'd16);     // r7 non-zero in second field
    do_reset();
    step(1'b0, "eqz_fwd"); step(1'b0, "eqz_fwd"); step(1'b0, "eqz_fwd");
    chk("R4 redirect taken", {31'h0, redirect}, 32'h1);
    chk("R3 rs_addr", {27'h0, rs_addr}, 32'd9);
    chk("R7 forward target", next_pc, 32'd28);
    step(1'b0, "eqz_fwd");
    chk("R8 bubble", id_instr, 32'h0);
    chk("R8 fetch at target", fetch_pc, 32'd28);
    for (int i = 0; i < 3; i++) step(1'b0, "eqz_fwd");
  endtask

  task automatic t_eqz_not_taken();
    clear_prog();
    imem[1] = enc(6'h04, 5'd5, 5'd0, 16'd40);
    do_reset();
    step(1'b0, "eqz_nt"); step(1'b0, "eqz_nt");
    chk("R4 not taken", {31'h0, redirect}, 32'h0);
    chk("R4 next sequential", next_pc, 32'd12);
    for (int i = 0; i < 3; i++) step(1'b0, "eqz_nt");
  endtask

  task automatic t_nez_backward();
    clear_prog();
    imem[3] = enc(6'h05, 5'd0, 5'd4, 16'h0100);   // r0 zero: not taken
    imem[5] = enc(6'h05, 5'd2, 5'd0, 16'hFFF0);   // back to 8
    do_reset();
    for (int i = 0; i < 4; i++) step(1'b0, "nez_bwd");
    chk("R5 not taken on zero", {31'h0, redirect}, 32'h0);
    step(1'b0, "nez_bwd"); step(1'b0, "nez_bwd");
    chk("R5 taken on non-zero", {31'h0, redirect}, 32'h1);
    chk("R7 backward target", next_pc, 32'd8);
    step(1'b0, "nez_bwd");
    chk("R8 fetch at backward target", fetch_pc, 32'd8);
    for (int i = 0; i < 10; i++) step(1'b0, "nez_bwd");
  endtask

  task automatic t_stall();
    clear_prog();
    regs[9] = 32'h0;
    imem[2] = enc(6'h04, 5'd9, 5'd0, 16'h0020);
    do_reset();
    step(1'b1, "stall_start");
    chk("R9 hold at start", fetch_pc, 32'h0);
    step(1'b0, "stall"); step(1'b0, "stall"); step(1'b0, "stall");
    for (int i = 0; i < 3; i++) begin
      step(1'b1, "stall_br");
      chk("R9 pc held", fetch_pc, 32'd12);
      chk("R9 redirect held", {31'h0, redirect}, 32'h1);
      chk("R9 next_pc held", next_pc, 32'd44);
    end
    step(1'b0, "stall_release");
    chk("R8 target after stall", fetch_pc, 32'd44);
    chk("R8 single bubble", id_instr, 32'h0);
    step(1'b0, "stall_after");
    chk("R8 no repeat squash", fetch_pc, 32'd48);
  endtask

  task automatic t_fields();
    clear_prog();
    imem[0] = enc(6'h3F, 5'd17, 5'd3, 16'h1234);
    imem[1] = enc(6'h04, 5'd0, 5'd31, 16'h0008);   // r31 non-zero in ignored field
    do_reset();
    step(1'b0, "fields");
    chk("R3 rs index", {27'h0, rs_addr}, 32'd17);
    chk("R6 opcode 3F quiet", {31'h0, redirect}, 32'h0);
    step(1'b0, "fields");
    chk("R3 second field ignored", {31'h0, redirect}, 32'h1);
    chk("R7 target", next_pc, 32'd16);
    step(1'b0, "fields");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    clear_prog();
    t_sequential();
    t_eqz_forward();
    t_eqz_not_taken();
    t_nez_backward();
    t_stall();
    t_fields();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule